// File: doc/BRIEF.md
# Way-Predicted Two-Way Read Cache

This block is a small read-only cache controller with set-associative storage. Every set remembers which of its ways it expects the next access to use. A new request is compared against the tag of that way only, and a match returns data on the cycle after acceptance. When that one comparison fails, the controller spends a cycle comparing every way of the set. A match found this way returns data three cycles after acceptance and re-aims the set's prediction at the way that matched. If no way matches, the controller fetches the word over a blocking refill port, writes it into a chosen way, aims the prediction there and returns the word.

The requester sees a valid/ready request port and a one-cycle response pulse. The pulse carries the data, a hit flag and a latency class, so a caller can tell how each access was served. Only one request is outstanding at a time. The next request may be presented in the cycle in which the previous response appears.

Top module: `wp_cache`

## Requirements
- R1: After reset, req_ready is 1 and rsp_valid and mem_req are 0. Every line is invalid, so the first access to any address is a miss. The prediction of every set is way 0.
- R2: A request whose tag matches the predicted way of its set is a fast hit. rsp_valid is high in the cycle right after the acceptance edge, with rsp_kind 2'b00, rsp_hit 1 and the stored data. mem_req stays 0.
- R3: A request that misses the predicted way but matches another valid way is a slow hit. rsp_valid is high in the third cycle after the acceptance edge, with rsp_kind 2'b01, rsp_hit 1 and the stored data. mem_req stays 0.
- R4: After a slow hit, the set's prediction points at the way that matched, so an immediate repeat of the same address is a fast hit.
- R5: A request that matches no way raises mem_req with mem_addr equal to the request address until mem_valid. The response follows in the cycle after mem_valid, with rsp_kind 2'b10, rsp_hit 0 and rsp_data equal to mem_data.
- R6: On a miss, the line goes into the lowest-numbered invalid way of the set. If no way is invalid, it goes into the way after the predicted one (the other way in a two-way cache). The prediction is set to the filled way.
- R7: req_ready is 0 from the cycle after acceptance until the response cycle, in which it is 1 again. A request presented in the response cycle is accepted at the next edge.
- R8: Lookups, fills and prediction updates in one set leave the lines and the prediction of every other set unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_addr | input | ADDR_W | Word address of the request |
| req_ready | output | 1 | Controller idle and able to accept |
| rsp_valid | output | 1 | One-cycle response pulse |
| rsp_data | output | DATA_W | Returned word |
| rsp_hit | output | 1 | 1 when served from the cache |
| rsp_kind | output | 2 | 00 fast hit, 01 slow hit, 10 miss |
| mem_req | output | 1 | Refill request held until mem_valid |
| mem_addr | output | ADDR_W | Refill word address |
| mem_valid | input | 1 | Refill data present |
| mem_data | input | DATA_W | Refill word |

## Verification
Two things can fall in the same cycle. One is the delivery of a response together with the acceptance of the next request. The other is a prediction rewritten at the end of a slow hit or fill while the next lookup reads that same prediction. The bench issues its requests back to back, so each new request arrives in the response cycle of the previous one, often to the same set whose prediction has just changed. Each case is judged by the latency class, the cycle count and the data of the following access. For example, a repeat right after a slow hit must come back fast, and an address that should have been evicted must miss.

// File: rtl/wp_cache_pkg.sv
`timescale 1ns/1ps
package wp_cache_pkg;
   typedef enum logic [1:0] {
      KIND_FAST = 2'b00,
      KIND_SLOW = 2'b01,
      KIND_MISS = 2'b10
   } rsp_kind_t;

   typedef enum logic [1:0] {
      ST_IDLE,
      ST_CHECK,
      ST_SLOW,
      ST_FILL
   } ctl_state_t;
endpackage

// File: rtl/wp_line_store.sv
`timescale 1ns/1ps
module wp_line_store #(
   parameter int WAYS   = 2,
   parameter int SETS   = 16,
   parameter int TAG_W  = 8,
   parameter int DATA_W = 32,
   localparam int IDX_W = $clog2(SETS),
   localparam int WAY_W = $clog2(WAYS)
) (
   input  logic                           clk,
   input  logic                           rst_n,
   input  logic [IDX_W-1:0]               rd_idx,
   input  logic                           wr_en,
   input  logic [WAY_W-1:0]               wr_way,
   input  logic [IDX_W-1:0]               wr_idx,
   input  logic [TAG_W-1:0]               wr_tag,
   input  logic [DATA_W-1:0]              wr_data,
   output logic [WAYS-1:0]                rd_valid,
   output logic [WAYS-1:0][TAG_W-1:0]     rd_tag,
   output logic [WAYS-1:0][DATA_W-1:0]    rd_data
);
   for (genvar w = 0; w < WAYS; w++) begin : g_way
      logic [SETS-1:0]   vld;
      logic [TAG_W-1:0]  tag_mem [SETS];
      logic [DATA_W-1:0] dat_mem [SETS];
      logic              sel;

      assign sel = wr_en && (wr_way == WAY_W'(w));

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)   vld <= '0;
         else if (sel) vld[wr_idx] <= 1'b1;
      end

      always_ff @(posedge clk) begin
         if (sel) begin
            tag_mem[wr_idx] <= wr_tag;
            dat_mem[wr_idx] <= wr_data;
         end
      end

      assign rd_valid[w] = vld[rd_idx];
      assign rd_tag[w]   = tag_mem[rd_idx];
      assign rd_data[w]  = dat_mem[rd_idx];
   end
endmodule

// File: rtl/wp_pred_table.sv
`timescale 1ns/1ps
module wp_pred_table #(
   parameter int WAYS = 2,
   parameter int SETS = 16,
   localparam int IDX_W = $clog2(SETS),
   localparam int WAY_W = $clog2(WAYS)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [IDX_W-1:0] rd_idx,
   input  logic             upd_en,
   input  logic [IDX_W-1:0] upd_idx,
   input  logic [WAY_W-1:0] upd_way,
   output logic [WAY_W-1:0] rd_way
);
   logic [WAY_W-1:0] guess [SETS];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int s = 0; s < SETS; s++) guess[s] <= '0;
      end else if (upd_en) begin
         guess[upd_idx] <= upd_way;
      end
   end

   assign rd_way = guess[rd_idx];
endmodule

// File: rtl/wp_way_match.sv
`timescale 1ns/1ps
module wp_way_match #(
   parameter int WAYS  = 2,
   parameter int TAG_W = 8,
   localparam int WAY_W = $clog2(WAYS)
) (
   input  logic [WAYS-1:0]            valid,
   input  logic [WAYS-1:0][TAG_W-1:0] tags,
   input  logic [TAG_W-1:0]           look_tag,
   input  logic [WAY_W-1:0]           pred_way,
   output logic                       pred_hit,
   output logic                       any_hit,
   output logic [WAY_W-1:0]           hit_way,
   output logic [WAY_W-1:0]           victim_way
);
   logic [WAYS-1:0]  match;
   logic [WAY_W-1:0] other_way;

   // single comparator for the first attempt
   assign pred_hit = valid[pred_way] && (tags[pred_way] == look_tag);

   always_comb begin
      match = '0;
      for (int w = 0; w < WAYS; w++) match[w] = valid[w] && (tags[w] == look_tag);
   end

   assign any_hit = |match;

   always_comb begin
      hit_way = '0;
      for (int w = WAYS - 1; w >= 0; w--) if (match[w]) hit_way = WAY_W'(w);
   end

   if (WAYS == 2) begin : g_pair
      assign other_way = ~pred_way;
   end else begin : g_ring
      assign other_way = pred_way + WAY_W'(1);
   end

   always_comb begin
      victim_way = other_way;
      for (int w = WAYS - 1; w >= 0; w--) if (!valid[w]) victim_way = WAY_W'(w);
   end
endmodule

// File: rtl/wp_cache.sv
`timescale 1ns/1ps
module wp_cache
   import wp_cache_pkg::*;
#(
   parameter int ADDR_W = 12,
   parameter int DATA_W = 32,
   parameter int SETS   = 16,
   parameter int WAYS   = 2,
   localparam int IDX_W = $clog2(SETS),
   localparam int WAY_W = $clog2(WAYS),
   localparam int TAG_W = ADDR_W - IDX_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic [ADDR_W-1:0] req_addr,
   output logic              req_ready,
   output logic              rsp_valid,
   output logic [DATA_W-1:0] rsp_data,
   output logic              rsp_hit,
   output logic [1:0]        rsp_kind,
   output logic              mem_req,
   output logic [ADDR_W-1:0] mem_addr,
   input  logic              mem_valid,
   input  logic [DATA_W-1:0] mem_data
);
   if (SETS < 2 || (SETS & (SETS - 1)) != 0) begin : g_bad_sets
      $error("SETS must be a power of two of at least 2");
   end
   if (WAYS < 2 || (WAYS & (WAYS - 1)) != 0) begin : g_bad_ways
      $error("WAYS must be a power of two of at least 2");
   end
   if (TAG_W < 1) begin : g_bad_addr
      $error("ADDR_W must exceed the index width");
   end

   ctl_state_t              state;
   logic [ADDR_W-1:0]       held_addr;
   logic [WAY_W-1:0]        hit_way_q, victim_q;
   logic [DATA_W-1:0]       slow_data_q;

   logic [IDX_W-1:0]        look_idx;
   logic [TAG_W-1:0]        look_tag;
   logic [WAYS-1:0]         way_valid;
   logic [WAYS-1:0][TAG_W-1:0]  way_tag;
   logic [WAYS-1:0][DATA_W-1:0] way_data;
   logic [WAY_W-1:0]        pred_way, hit_way, victim_way;
   logic                    pred_hit, any_hit;
   logic                    fill_done, upd_en;
   logic [WAY_W-1:0]        upd_way;

   // idle looks up the incoming address, later states the held one
   assign look_idx  = (state == ST_IDLE) ? req_addr[IDX_W-1:0]      : held_addr[IDX_W-1:0];
   assign look_tag  = (state == ST_IDLE) ? req_addr[ADDR_W-1:IDX_W] : held_addr[ADDR_W-1:IDX_W];
   assign req_ready = (state == ST_IDLE);
   assign mem_req   = (state == ST_FILL);
   assign mem_addr  = held_addr;
   assign fill_done = (state == ST_FILL) && mem_valid;
   assign upd_en    = (state == ST_SLOW) || fill_done;
   assign upd_way   = (state == ST_SLOW) ? hit_way_q : victim_q;

   wp_line_store #(.WAYS(WAYS), .SETS(SETS), .TAG_W(TAG_W), .DATA_W(DATA_W)) i_store (
      .clk(clk), .rst_n(rst_n), .rd_idx(look_idx),
      .wr_en(fill_done), .wr_way(victim_q), .wr_idx(held_addr[IDX_W-1:0]),
      .wr_tag(held_addr[ADDR_W-1:IDX_W]), .wr_data(mem_data),
      .rd_valid(way_valid), .rd_tag(way_tag), .rd_data(way_data)
   );

   wp_pred_table #(.WAYS(WAYS), .SETS(SETS)) i_pred (
      .clk(clk), .rst_n(rst_n), .rd_idx(look_idx),
      .upd_en(upd_en), .upd_idx(held_addr[IDX_W-1:0]), .upd_way(upd_way),
      .rd_way(pred_way)
   );

   wp_way_match #(.WAYS(WAYS), .TAG_W(TAG_W)) i_match (
      .valid(way_valid), .tags(way_tag), .look_tag(look_tag), .pred_way(pred_way),
      .pred_hit(pred_hit), .any_hit(any_hit), .hit_way(hit_way), .victim_way(victim_way)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state       <= ST_IDLE;
         held_addr   <= '0;
         hit_way_q   <= '0;
         victim_q    <= '0;
         slow_data_q <= '0;
         rsp_valid   <= 1'b0;
         rsp_data    <= '0;
         rsp_hit     <= 1'b0;
         rsp_kind    <= KIND_FAST;
      end else begin
         rsp_valid <= 1'b0;
         unique case (state)
            ST_IDLE: begin
               if (req_valid) begin
                  held_addr <= req_addr;
                  if (pred_hit) begin
                     rsp_valid <= 1'b1;
                     rsp_data  <= way_data[pred_way];
                     rsp_hit   <= 1'b1;
                     rsp_kind  <= KIND_FAST;
                  end else begin
                     state <= ST_CHECK;
                  end
               end
            end
            ST_CHECK: begin
               hit_way_q   <= hit_way;
               victim_q    <= victim_way;
               slow_data_q <= way_data[hit_way];
               state       <= any_hit ? ST_SLOW : ST_FILL;
            end
            ST_SLOW: begin
               rsp_valid <= 1'b1;
               rsp_data  <= slow_data_q;
               rsp_hit   <= 1'b1;
               rsp_kind  <= KIND_SLOW;
               state     <= ST_IDLE;
            end
            ST_FILL: begin
               if (mem_valid) begin
                  rsp_valid <= 1'b1;
                  rsp_data  <= mem_data;
                  rsp_hit   <= 1'b0;
                  rsp_kind  <= KIND_MISS;
                  state     <= ST_IDLE;
               end
            end
            default: state <= ST_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/wp_cache_chk.sv
`timescale 1ns/1ps
module wp_cache_chk #(
   parameter int ADDR_W = 12,
   parameter int DATA_W = 32
) (
   input logic              clk,
   input logic              rst_n,
   input logic              req_valid,
   input logic [ADDR_W-1:0] req_addr,
   input logic              req_ready,
   input logic              rsp_valid,
   input logic [DATA_W-1:0] rsp_data,
   input logic              rsp_hit,
   input logic [1:0]        rsp_kind,
   input logic              mem_req,
   input logic [ADDR_W-1:0] mem_addr,
   input logic              mem_valid,
   input logic [DATA_W-1:0] mem_data
);
   logic [ADDR_W-1:0] last_req_addr;
   logic [DATA_W-1:0] last_rsp_data, last_mem_data;
   assign last_req_addr = req_addr;
   assign last_rsp_data = rsp_data;
   assign last_mem_data = mem_data;

   // R2
   fast_one_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && rsp_kind == 2'b00) |-> $past(req_valid && req_ready));

   // R3
   slow_three_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && rsp_kind == 2'b01) |->
         ($past(req_valid && req_ready, 3) && !$past(req_ready, 2) && !$past(req_ready, 1)));

   // R3
   hit_no_refill_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && rsp_hit) |-> !$past(mem_req));

   // R5
   hit_flag_kind_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |-> (rsp_hit == (rsp_kind != 2'b10)));

   // R5
   refill_response_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && mem_valid) |=> (rsp_valid && rsp_kind == 2'b10 && rsp_data == $past(last_mem_data)));

   // R5
   refill_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && $past(mem_req)) |-> $stable(mem_addr));

   // R7
   refill_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req |-> !req_ready);

   // R7
   accept_then_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_ready) |=> (rsp_valid || !req_ready));

   // R7
   response_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |-> req_ready);
endmodule

bind wp_cache wp_cache_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_wp_cache_chk (
   .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
   .req_ready(req_ready), .rsp_valid(rsp_valid), .rsp_data(rsp_data),
   .rsp_hit(rsp_hit), .rsp_kind(rsp_kind), .mem_req(mem_req),
   .mem_addr(mem_addr), .mem_valid(mem_valid), .mem_data(mem_data)
);

// File: tb/test_wp_cache.sv
`timescale 1ns/1ps
module test_wp_cache;
   localparam int AW = 12;
   localparam int DW = 32;
   localparam int MEM_DLY = 3;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          req_valid = 1'b0;
   logic [AW-1:0] req_addr = '0;
   logic          req_ready, rsp_valid, rsp_hit, mem_req;
   logic [DW-1:0] rsp_data;
   logic [1:0]    rsp_kind;
   logic [AW-1:0] mem_addr;
   logic          mem_valid = 1'b0;
   logic [DW-1:0] mem_data = '0;

   int errors = 0;
   int checks = 0;
   bit done = 1'b0;
   logic [AW-1:0] seen_mem_addr;

   always #2.5 clk = ~clk;

   wp_cache #(.ADDR_W(AW), .DATA_W(DW), .SETS(16), .WAYS(2)) i_wp_cache (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
      .req_ready(req_ready), .rsp_valid(rsp_valid), .rsp_data(rsp_data),
      .rsp_hit(rsp_hit), .rsp_kind(rsp_kind), .mem_req(mem_req),
      .mem_addr(mem_addr), .mem_valid(mem_valid), .mem_data(mem_data)
   );

   function automatic logic [DW-1:0] word_of(input logic [AW-1:0] a);
      return {a, 4'h5, ~a, 4'hA};
   endfunction

   task automatic check(input bit ok, input string req, input string what,
                        input logic [DW-1:0] act, input logic [DW-1:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   // behavioural refill memory, driven at falling edges
   initial begin
      int wait_n = 0;
      forever begin
         @(negedge clk);
         if (mem_valid) begin
            mem_valid = 1'b0;
            wait_n = 0;
         end else if (mem_req) begin
            wait_n++;
            if (wait_n == MEM_DLY) begin
               seen_mem_addr = mem_addr;
               mem_data  = word_of(mem_addr);
               mem_valid = 1'b1;
            end
         end
      end
   end

   // kind: 0 fast, 1 slow, 2 miss; called at a falling edge
   task automatic access(input logic [AW-1:0] a, input logic [1:0] kind, input string req);
      int  lat = 0;
      bit  busy_bad = 1'b0;
      bit  saw_mem = 1'b0;
      check(req_ready == 1'b1, "R7", "ready before request", DW'(req_ready), 1);
      req_valid = 1'b1;
      req_addr  = a;
      @(posedge clk);
      @(negedge clk);
      req_valid = 1'b0;
      lat = 1;
      while (!rsp_valid && lat < 100) begin
         if (req_ready) busy_bad = 1'b1;
         if (mem_req) saw_mem = 1'b1;
         @(negedge clk);
         lat++;
      end
      check(rsp_valid == 1'b1, req, "response seen", DW'(rsp_valid), 1);
      check(rsp_kind == kind, req, "latency class", DW'(rsp_kind), DW'(kind));
      check(rsp_hit == (kind != 2'd2), req, "hit flag", DW'(rsp_hit), DW'(kind != 2'd2));
      check(rsp_data == word_of(a), req, "data", rsp_data, word_of(a));
      check(!busy_bad, "R7", "ready low while busy", DW'(busy_bad), 0);
      check(req_ready == 1'b1, "R7", "ready in response cycle", DW'(req_ready), 1);
      if (kind == 2'd0) check(lat == 1, "R2", "fast latency", DW'(lat), 1);
      if (kind == 2'd1) check(lat == 3, "R3", "slow latency", DW'(lat), 3);
      if (kind != 2'd2) check(!saw_mem, req, "no refill on hit", DW'(saw_mem), 0);
      if (kind == 2'd2) begin
         check(saw_mem, "R5", "refill requested", DW'(saw_mem), 1);
         check(seen_mem_addr == a, "R5", "refill address", DW'(seen_mem_addr), DW'(a));
         check(lat > 3, "R5", "miss waits for refill", DW'(lat), 4);
      end
   endtask

   localparam logic [AW-1:0] A = 12'h013, B = 12'h023, C = 12'h033, D = 12'h015;

   task automatic t_reset();
      check(req_ready == 1'b1, "R1", "ready after reset", DW'(req_ready), 1);
      check(rsp_valid == 1'b0, "R1", "no response after reset", DW'(rsp_valid), 0);
      check(mem_req == 1'b0, "R1", "no refill after reset", DW'(mem_req), 0);
   endtask

   task automatic t_cold_and_fast();
      access(A, 2'd2, "R1");   // cold line, fills way 0
      access(A, 2'd0, "R2");   // way 0 predicted after reset and fill
   endtask

   task automatic t_second_fill();
      access(B, 2'd2, "R6");   // way 1 invalid, filled there, predicted
      access(B, 2'd0, "R6");
   endtask

   task automatic t_mispredict();
      access(A, 2'd1, "R3");   // predicted way 1 holds B
      access(A, 2'd0, "R4");   // prediction moved to way 0
   endtask

   task automatic t_evict();
      access(C, 2'd2, "R6");   // both valid, prediction 0, replaces way 1 (B)
      access(C, 2'd0, "R6");
      access(A, 2'd1, "R6");   // A kept in way 0
      access(B, 2'd2, "R6");   // B was evicted; replaces C in way 1
   endtask

   task automatic t_other_set();
      access(D, 2'd2, "R8");   // set 5 still empty
      access(D, 2'd0, "R8");
      access(B, 2'd0, "R8");   // set 3 prediction untouched by set 5
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      checks++;
      errors++;
      $display("FAIL watchdog: actual=expired expected=done");
      finish_run();
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_cold_and_fast();
      t_second_fill();
      t_mispredict();
      t_evict();
      t_other_set();
      repeat (2) @(negedge clk);
      finish_run();
   end
endmodule